// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns parallel audio sample words into serial bit streams on up to four data lanes, with a bit clock and a frame clock alongside them. The framing is one of standard I2S, left-justified, right-justified or PCM short-frame. PCM framing has two alignments: data starts in the same slot as the frame pulse, or one slot after it. The sample width (8, 16, 20, 24 or 32 bits), the number of channels (2, 4, 6 or 8, one stereo pair per lane) and the polarity of each clock are configuration inputs. The block runs on a fast system clock. An external divider supplies a one-cycle `half_tick` strobe for every half period of the bit clock.

At the start of every frame the block takes a full set of words from the transmit FIFO and raises `fetch`. If the FIFO has nothing to offer, it raises `underrun` and sends zeros for that frame. A frame has `FRAME_BITS` slots, 64 by default. Slots 0 to 31 are the left half-frame and slots 32 to 63 are the right half-frame.

A three-state machine steps the bit clock. The states are IDLE (bit clock low, outputs quiet), LOW (bit clock low, new data on the lanes) and HIGH (bit clock high, data held for the receiver to sample). The named transitions are:
- START: IDLE to LOW on a tick while `run` is high, entering slot 0.
- RISE: LOW to HIGH on any tick.
- FALL: HIGH to LOW on a tick while `run` is high, advancing the slot. The last slot WRAPs to slot 0.
- STOP: HIGH to IDLE on a tick while `run` is low.

Top module: `audio_serial_tx`

## Requirements
- R1: After reset and while idle, every lane is 0, `fetch` and `underrun` are 0, `bclk` equals `bclk_inv` and `fclk` equals `fclk_inv`.
- R2: The state moves only on a `half_tick`. Lane data changes only together with a falling logical bit-clock edge or a frame-start strobe, never at a rising edge.
- R3: Slots count 0 to `FRAME_BITS`-1 and wrap. The first `FRAME_BITS`/2 slots carry the left word of each lane and the rest carry the right word.
- R4: With `fmt`=0 (I2S), each word's MSB goes out one slot after the half-frame begins, W bits follow, and the remaining slots are 0. The logical frame clock is low for the left half and high for the right half.
- R5: With `fmt`=1 (left-justified), each word's MSB goes out in the first slot of its half-frame, followed by W-1 more bits and then zeros. The logical frame clock is high for the left half.
- R6: With `fmt`=2 (right-justified), each word's LSB goes out in the last slot of its half-frame and the leading slots are 0. The logical frame clock is high for the left half.
- R7: With `fmt`=3 (PCM), the logical frame clock is high only in slot 0. The left word (W bits, MSB first) is followed directly by the right word, and later slots are 0. With `pcm_dly`=0 the left MSB is in slot 0; with `pcm_dly`=1 the whole data stream is one slot later.
- R8: `wcode` 0, 1, 2, 3 and 4 select W = 8, 16, 20, 24 and 32; codes 5 to 7 act as 32. The valid bits are word bits W-1..0, and bits above W-1 have no effect on the lanes.
- R9: `ch_sel` = c enables lanes 0..c. Lane l carries the words at `tx_words` bits [(2l)*32 +: 32] (left) and [(2l+1)*32 +: 32] (right). Disabled lanes stay 0.
- R10: `bclk` is the logical bit clock XOR `bclk_inv`, and `fclk` is the logical frame clock XOR `fclk_inv`. The two inversions are independent.
- R11: At every frame start with `fifo_valid` high, `fetch` pulses for one cycle. The words are captured at that moment and held for the whole frame, even if `tx_words` changes afterwards.
- R12: At a frame start with `fifo_valid` low, `underrun` pulses instead of `fetch`, and all lanes send zeros for that frame.
- R13: Dropping `run` ends the current bit at its falling edge, clears the lanes and returns to IDLE. Raising `run` again starts a fresh frame at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables transmission |
| half_tick | input | 1 | One-cycle strobe per half bit-clock period |
| fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 PCM |
| pcm_dly | input | 1 | PCM data offset of one slot after the frame pulse |
| wcode | input | 3 | Sample width code |
| ch_sel | input | 2 | Number of active lanes minus one |
| bclk_inv | input | 1 | Inverts the bit clock |
| fclk_inv | input | 1 | Inverts the frame clock |
| fifo_valid | input | 1 | FIFO has a full sample set |
| tx_words | input | LANES*64 | Left/right words per lane |
| fetch | output | 1 | Sample set consumed |
| underrun | output | 1 | Frame started with no samples |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock |
| sdo | output | LANES | Serial data lanes |

## Verification
The hardest situation to reach is the slot-0 bit of a delayed format (I2S, or PCM with a one-slot delay) at full width. That bit belongs to the previous frame's right word, so it only appears once a frame has already run. The bench therefore lets each delayed-format scenario run one frame with unchanged words and checks the second frame slot by slot. A separate scenario changes `tx_words` right after `fetch` to show that the captured set, not the live input, is transmitted.

// File: rtl/atx_pkg.sv
package atx_pkg;

    localparam int SLOT_W = 32;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_RIGHT = 2'd2,
        FMT_PCM   = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } phase_e;

    function automatic int width_of(logic [2:0] code);
        case (code)
            3'd0:    return 8;
            3'd1:    return 16;
            3'd2:    return 20;
            3'd3:    return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic bit_at(logic [SLOT_W-1:0] v, int idx);
        logic [SLOT_W-1:0] t;
        t = v >> idx;
        return t[0];
    endfunction

endpackage

// File: rtl/atx_timing.sv
module atx_timing
    import atx_pkg::*;
#(
    parameter int FRAME_BITS = 64,
    parameter int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             half_tick,
    input  logic [1:0]       fmt,
    output logic             adv,
    output logic             to_idle,
    output logic [CNT_W-1:0] slot_next,
    output logic [CNT_W-1:0] slot_q,
    output logic             bclk_ph,
    output logic             fclk_lvl_q
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] HALF_IDX = CNT_W'(FRAME_BITS / 2);

    phase_e state_q, state_d;
    logic   lvl_d;

    // next state: START, RISE, FALL (with WRAP), STOP
    always_comb begin
        state_d   = state_q;
        slot_next = slot_q;
        adv       = 1'b0;
        to_idle   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (half_tick && run) begin
                    state_d   = ST_LOW;
                    slot_next = '0;
                    adv       = 1'b1;
                end
            end
            ST_LOW: begin
                if (half_tick) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (half_tick) begin
                    if (run) begin
                        state_d   = ST_LOW;
                        adv       = 1'b1;
                        slot_next = (slot_q == LAST_IDX) ? '0 : slot_q + 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                        to_idle = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // logical frame-clock level for the slot being entered
    always_comb begin
        unique case (fmt_e'(fmt))
            FMT_I2S:             lvl_d = (slot_next >= HALF_IDX);
            FMT_LEFT, FMT_RIGHT: lvl_d = (slot_next < HALF_IDX);
            FMT_PCM:             lvl_d = (slot_next == '0);
            default:             lvl_d = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_next;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fclk_lvl_q <= 1'b0;
        end else if (adv) begin
            fclk_lvl_q <= lvl_d;
        end else if (to_idle) begin
            fclk_lvl_q <= 1'b0;
        end
    end

    assign bclk_ph = (state_q == ST_HIGH);

    a_r2_move_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> $stable(state_q));

    a_r3_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && half_tick && run && slot_q != LAST_IDX)
        |=> (slot_q == $past(slot_q) + 1'b1));

    a_r3_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && half_tick && run && slot_q == LAST_IDX)
        |=> (slot_q == '0));

    a_r7_pcm_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && fmt == FMT_PCM && slot_q != '0) |-> !fclk_lvl_q);

    a_r13_restart_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && half_tick && run) |=> (state_q == ST_LOW && slot_q == '0));

endmodule

// File: rtl/atx_lane.sv
module atx_lane
    import atx_pkg::*;
#(
    parameter int LANE_ID    = 0,
    parameter int FRAME_BITS = 64,
    parameter int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic                to_idle,
    input  logic [CNT_W-1:0]    slot_next,
    input  logic                fresh,
    input  logic [2*SLOT_W-1:0] words_in,
    input  logic [1:0]          fmt,
    input  logic                pcm_dly,
    input  logic [2:0]          wcode,
    input  logic [1:0]          ch_sel,
    output logic                sdo_q
);

    localparam int HALF = FRAME_BITS / 2;

    logic [SLOT_W-1:0] left_q, right_q, src_l, src_r;
    logic first, active, delayed, raw, dly_q;

    assign first   = (slot_next == '0);
    assign active  = (LANE_ID <= int'(ch_sel));
    assign delayed = (fmt_e'(fmt) == FMT_I2S) || (fmt_e'(fmt) == FMT_PCM && pcm_dly);
    assign src_l   = first ? (fresh ? words_in[SLOT_W-1:0] : '0) : left_q;
    assign src_r   = first ? (fresh ? words_in[2*SLOT_W-1:SLOT_W] : '0) : right_q;

    // bit that belongs in the slot being entered
    always_comb begin
        int n;
        int p;
        int w;
        logic [SLOT_W-1:0] wd;
        n   = int'(slot_next);
        w   = width_of(wcode);
        wd  = (n >= HALF) ? src_r : src_l;
        p   = (n >= HALF) ? n - HALF : n;
        raw = 1'b0;
        unique case (fmt_e'(fmt))
            FMT_I2S, FMT_LEFT: begin
                if (p < w) raw = bit_at(wd, w - 1 - p);
            end
            FMT_RIGHT: begin
                if (p >= HALF - w) raw = bit_at(wd, HALF - 1 - p);
            end
            FMT_PCM: begin
                if (n < w)          raw = bit_at(src_l, w - 1 - n);
                else if (n < 2 * w) raw = bit_at(src_r, 2 * w - 1 - n);
            end
            default: raw = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
        end else if (adv && first) begin
            left_q  <= src_l;
            right_q <= src_r;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
            dly_q <= 1'b0;
        end else if (to_idle) begin
            sdo_q <= 1'b0;
            dly_q <= 1'b0;
        end else if (adv) begin
            dly_q <= active ? raw : 1'b0;
            sdo_q <= active ? (delayed ? dly_q : raw) : 1'b0;
        end
    end

    a_r2_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !to_idle) |=> $stable(sdo_q));

    a_r9_disabled_lane_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && LANE_ID > int'(ch_sel)) |=> !sdo_q);

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
    import atx_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int FRAME_BITS = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      half_tick,
    input  logic [1:0]                fmt,
    input  logic                      pcm_dly,
    input  logic [2:0]                wcode,
    input  logic [1:0]                ch_sel,
    input  logic                      bclk_inv,
    input  logic                      fclk_inv,
    input  logic                      fifo_valid,
    input  logic [LANES*2*SLOT_W-1:0] tx_words,
    output logic                      fetch,
    output logic                      underrun,
    output logic                      bclk,
    output logic                      fclk,
    output logic [LANES-1:0]          sdo
);

    localparam int CNT_W  = $clog2(FRAME_BITS);
    localparam int PAIR_W = 2 * SLOT_W;

    logic             adv, to_idle, bclk_ph, fclk_lvl_q, frame_load;
    logic [CNT_W-1:0] slot_next, slot_q;

    atx_timing #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .half_tick  (half_tick),
        .fmt        (fmt),
        .adv        (adv),
        .to_idle    (to_idle),
        .slot_next  (slot_next),
        .slot_q     (slot_q),
        .bclk_ph    (bclk_ph),
        .fclk_lvl_q (fclk_lvl_q)
    );

    assign frame_load = adv && (slot_next == '0);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        atx_lane #(.LANE_ID(g), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .adv       (adv),
            .to_idle   (to_idle),
            .slot_next (slot_next),
            .fresh     (fifo_valid),
            .words_in  (tx_words[g*PAIR_W +: PAIR_W]),
            .fmt       (fmt),
            .pcm_dly   (pcm_dly),
            .wcode     (wcode),
            .ch_sel    (ch_sel),
            .sdo_q     (sdo[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch    <= 1'b0;
            underrun <= 1'b0;
        end else begin
            fetch    <= frame_load && fifo_valid;
            underrun <= frame_load && !fifo_valid;
        end
    end

    assign bclk = bclk_ph ^ bclk_inv;
    assign fclk = fclk_lvl_q ^ fclk_inv;

    a_r11_strobe_at_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch || underrun) |-> (slot_q == '0 && !bclk_ph));

    a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !fetch);

endmodule

// File: tb/sim_audio_serial_tx.sv
module sim_audio_serial_tx;

    localparam int PERIOD = 10;
    localparam int LANES  = 4;
    localparam int FB     = 64;
    localparam int HB     = FB / 2;

    logic clk = 1'b0;
    always #(PERIOD / 2) clk = ~clk;

    logic             rst_n, run, half_tick, cfg_dly, cfg_binv, cfg_finv, fifo_valid;
    logic [1:0]       cfg_fmt, cfg_ch;
    logic [2:0]       cfg_w;
    logic [LANES*64-1:0] words;
    logic             fetch, underrun, bclk, fclk;
    logic [LANES-1:0] sdo;

    audio_serial_tx #(.LANES(LANES), .FRAME_BITS(FB)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .half_tick(half_tick),
        .fmt(cfg_fmt), .pcm_dly(cfg_dly), .wcode(cfg_w), .ch_sel(cfg_ch),
        .bclk_inv(cfg_binv), .fclk_inv(cfg_finv), .fifo_valid(fifo_valid),
        .tx_words(words), .fetch(fetch), .underrun(underrun),
        .bclk(bclk), .fclk(fclk), .sdo(sdo)
    );

    int n_chk = 0;
    int n_bad = 0;
    int tick_cnt = 0;
    int viol = 0;
    bit mon_en = 0;
    logic [LANES-1:0] cap_sd [FB];
    logic             cap_fc [FB];
    logic [31:0]      ref_w [LANES][2];
    bit               cap_fetch_seen;

    initial begin
        half_tick = 1'b0;
        forever begin
            @(negedge clk);
            tick_cnt++;
            half_tick = (tick_cnt % 4 == 0);
        end
    end

    // R2 monitor: data may move only with a logical falling edge or a frame strobe
    logic mon_prev_b;
    logic [LANES-1:0] mon_prev_d;
    always @(negedge clk) begin
        if (mon_en) begin
            if (sdo !== mon_prev_d && !(mon_prev_b && !(bclk ^ cfg_binv)) && !fetch && !underrun)
                viol++;
        end
        mon_prev_b = bclk ^ cfg_binv;
        mon_prev_d = sdo;
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int wid(int code);
        if (code == 0) return 8;
        if (code == 1) return 16;
        if (code == 2) return 20;
        if (code == 3) return 24;
        return 32;
    endfunction

    function automatic logic raw_ref(int f, int w, int n, logic [31:0] lw, logic [31:0] rw);
        int p;
        logic [31:0] wd;
        p  = n % HB;
        wd = (n >= HB) ? rw : lw;
        if (f == 0 || f == 1) return (p < w) ? wd[w-1-p] : 1'b0;
        if (f == 2) return (p >= HB - w) ? wd[HB-1-p] : 1'b0;
        if (n < w) return lw[w-1-n];
        if (n < 2 * w) return rw[2*w-1-n];
        return 1'b0;
    endfunction

    function automatic logic bit_ref(int f, bit d, int w, int n, logic [31:0] lw, logic [31:0] rw);
        int m;
        m = (f == 0 || (f == 3 && d)) ? (n + FB - 1) % FB : n;
        return raw_ref(f, w, m, lw, rw);
    endfunction

    function automatic logic fclk_ref(int f, int n);
        if (f == 0) return n >= HB;
        if (f == 3) return n == 0;
        return n < HB;
    endfunction

    function automatic logic [31:0] pat(int l, int c, int seed);
        return 32'h9E37_79B9 * (2 * l + c + 1) + 32'(seed) * 32'h0101_7F35;
    endfunction

    task automatic load_words(int seed);
        for (int l = 0; l < LANES; l++)
            for (int c = 0; c < 2; c++)
                words[(2*l+c)*32 +: 32] = pat(l, c, seed);
    endtask

    task automatic snap(bit zero);
        for (int l = 0; l < LANES; l++)
            for (int c = 0; c < 2; c++)
                ref_w[l][c] = zero ? 32'h0 : words[(2*l+c)*32 +: 32];
    endtask

    task automatic stop_run();
        run = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic capture(bit want_under, bit swap_after);
        int guard;
        int k;
        logic prev, cur;
        guard = 0;
        k = 0;
        cap_fetch_seen = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!(want_under ? underrun : fetch) && guard < 4000);
        if (guard >= 4000) chk(want_under ? "R12" : "R11", "frame strobe seen", 0, 1);
        if (swap_after) load_words(77);
        prev = bclk ^ cfg_binv;
        while (k < FB && guard < 8000) begin
            @(negedge clk);
            guard++;
            if (fetch) cap_fetch_seen = 1;
            cur = bclk ^ cfg_binv;
            if (cur && !prev) begin
                cap_sd[k] = sdo;
                cap_fc[k] = fclk ^ cfg_finv;
                k++;
            end
            prev = cur;
        end
    endtask

    task automatic check_frame(string req);
        int f, w, ch, bad, first;
        logic eb, ab;
        f  = int'(cfg_fmt);
        w  = wid(int'(cfg_w));
        ch = int'(cfg_ch);
        for (int l = 0; l < LANES; l++) begin
            bad = 0;
            first = 0;
            eb = 0;
            ab = 0;
            for (int k = 0; k < FB; k++) begin
                logic e;
                e = (l <= ch) ? bit_ref(f, cfg_dly, w, k, ref_w[l][0], ref_w[l][1]) : 1'b0;
                if (cap_sd[k][l] !== e) begin
                    if (bad == 0) begin
                        first = k;
                        eb = e;
                        ab = cap_sd[k][l];
                    end
                    bad++;
                end
            end
            n_chk++;
            if (bad != 0) begin
                n_bad++;
                $display("FAIL %s lane %0d slot %0d: actual %0b expected %0b", req, l, first, ab, eb);
            end
        end
        bad = 0;
        for (int k = 0; k < FB; k++)
            if (cap_fc[k] !== fclk_ref(f, k)) begin
                if (bad == 0)
                    $display("FAIL %s frame clock slot %0d: actual %0b expected %0b",
                             req, k, cap_fc[k], fclk_ref(f, k));
                bad++;
            end
        n_chk++;
        if (bad != 0) n_bad++;
    endtask

    task automatic set_cfg(int f, bit d, int wc, int ch, bit bi, bit fi);
        cfg_fmt  = 2'(f);
        cfg_dly  = d;
        cfg_w    = 3'(wc);
        cfg_ch   = 2'(ch);
        cfg_binv = bi;
        cfg_finv = fi;
    endtask

    task automatic t_reset();
        chk("R1", "lanes after reset", 64'(sdo), 0);
        chk("R1", "bclk after reset", 64'(bclk), 0);
        chk("R1", "fclk after reset", 64'(fclk), 0);
        chk("R1", "strobes after reset", 64'({fetch, underrun}), 0);
        cfg_binv = 1'b1;
        cfg_finv = 1'b1;
        @(negedge clk);
        chk("R1", "idle bclk follows inversion", 64'(bclk), 1);
        chk("R1", "idle fclk follows inversion", 64'(fclk), 1);
        cfg_binv = 1'b0;
        cfg_finv = 1'b0;
    endtask

    // R4, R8 (24-bit), R9 (all lanes)
    task automatic t_i2s24();
        set_cfg(0, 0, 3, 3, 0, 0);
        load_words(1);
        snap(0);
        run = 1'b1;
        capture(0, 0);
        capture(0, 0);
        check_frame("R4");
        stop_run();
    endtask

    // R4, R8: code 7 acts as 32 bits, slot 0 carries previous right LSB
    task automatic t_i2s32();
        set_cfg(0, 0, 7, 3, 0, 0);
        load_words(2);
        snap(0);
        run = 1'b1;
        capture(0, 0);
        capture(0, 0);
        check_frame("R8");
        stop_run();
    endtask

    // R5, R8: upper bits above 16 are junk and must not appear
    task automatic t_left16();
        set_cfg(1, 0, 1, 3, 0, 0);
        load_words(3);
        snap(0);
        run = 1'b1;
        capture(0, 0);
        check_frame("R5");
        stop_run();
    endtask

    // R6, R9: 20-bit right-justified on two lanes only
    task automatic t_right20();
        set_cfg(2, 0, 2, 1, 0, 0);
        load_words(4);
        snap(0);
        run = 1'b1;
        capture(0, 0);
        check_frame("R6");
        chk("R9", "disabled lanes quiet", 64'(sdo[3:2]), 0);
        stop_run();
    endtask

    // R7: no delay
    task automatic t_pcm0();
        set_cfg(3, 0, 1, 3, 0, 0);
        load_words(5);
        snap(0);
        run = 1'b1;
        capture(0, 0);
        check_frame("R7");
        stop_run();
    endtask

    // R7, R10, R13: one-slot delay, both clocks inverted, then stop
    task automatic t_pcm1_inv();
        int extra;
        set_cfg(3, 1, 0, 2, 1, 1);
        load_words(6);
        snap(0);
        run = 1'b1;
        capture(0, 0);
        capture(0, 0);
        check_frame("R10");
        run = 1'b0;
        repeat (40) @(negedge clk);
        chk("R13", "bclk idle level inverted", 64'(bclk), 1);
        chk("R13", "fclk idle level inverted", 64'(fclk), 1);
        chk("R13", "lanes cleared on stop", 64'(sdo), 0);
        extra = 0;
        repeat (600) begin
            @(negedge clk);
            if (fetch || underrun) extra++;
        end
        chk("R13", "no frames while stopped", 64'(extra), 0);
        cfg_binv = 1'b0;
        cfg_finv = 1'b0;
    endtask

    // R11: words captured at fetch and held for the frame
    task automatic t_hold();
        set_cfg(1, 0, 4, 3, 0, 0);
        load_words(8);
        snap(0);
        run = 1'b1;
        capture(0, 1);
        check_frame("R11");
        snap(0);
        capture(0, 0);
        check_frame("R11");
        stop_run();
    endtask

    // R12: empty FIFO sends zeros and flags underrun
    task automatic t_underrun();
        set_cfg(1, 0, 1, 3, 0, 0);
        load_words(9);
        fifo_valid = 1'b0;
        snap(1);
        run = 1'b1;
        capture(1, 0);
        check_frame("R12");
        chk("R12", "no fetch during underrun frame", 64'(cap_fetch_seen), 0);
        stop_run();
        fifo_valid = 1'b1;
    endtask

    // R13, R3: restart begins at slot 0 (first frame checked directly)
    task automatic t_restart();
        set_cfg(1, 0, 3, 3, 0, 0);
        load_words(10);
        snap(0);
        run = 1'b1;
        capture(0, 0);
        check_frame("R13");
        stop_run();
        chk("R2", "sdo moved only on falling edge or frame strobe", 64'(viol), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        run = 1'b0;
        fifo_valid = 1'b1;
        words = '0;
        set_cfg(0, 0, 1, 3, 0, 0);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1;
        t_reset();
        t_i2s24();
        t_i2s32();
        t_left16();
        t_right20();
        t_pcm0();
        t_pcm1_inv();
        t_hold();
        t_underrun();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule